// File: doc/BRIEF.md
# Instruction Byte Assembler

This block sits between an instruction byte source and a decode or execute stage. Bytes arrive one at a time over a valid/ready handshake. The first byte of each instruction is the opcode. Its bit pattern alone sets how many further bytes belong to the instruction: none, one or two. The block accepts those bytes and then presents one complete record. The record holds the opcode, the 8-bit operand, the 16-bit operand, the length, a class code, and a taken bit for control transfers.

For conditional jumps, calls and returns, the 3-bit condition field in the opcode is tested against a 4-bit flag vector. That vector is sampled in the same cycle the opcode byte is accepted. Unconditional transfers and restarts are always marked taken. All other instructions are marked not taken. A record stays on the output until the consumer accepts it. No new byte is accepted while a record is waiting.

Top module: `instr_gather`

## Requirements
- R1: After reset, `in_ready` is 1 and `rec_valid` is 0.
- R2: Opcodes 00ddd110 and 11xxx110 are two bytes long (`rec_len` = 2).
- R3: These opcodes are three bytes long (`rec_len` = 3): 00pp0001, 0x22, 0x2A, 0x32, 0x3A, 0xC3, 0xCD, 11ccc010 and 11ccc100.
- R4: Every opcode not named in R2 or R3 is one byte long (`rec_len` = 1). This includes 11ccc000, 0xC9, 11nnn111, 01dddsss, 10ooosss and 00xxx111.
- R5: `rec_imm8` holds the second byte, and is 0 for one-byte instructions. `rec_imm16` holds the third byte in bits 15:8 and the second byte in bits 7:0, and is 0 unless the length is 3.
- R6: `rec_valid` rises one cycle after the final byte is accepted. While it is high, `in_ready` is 0 and every record field holds steady until a cycle with `rec_ready` high. `rec_valid` is 0 in the cycle after that.
- R7: `rec_class` codes are assigned as follows:
  - 1: 01xxxxxx
  - 2: 10xxxxxx and 11xxx110
  - 3: 00ddd110 and 00pp0001
  - 4: 0x22, 0x2A, 0x32 and 0x3A
  - 5: 0xC3 and 11ccc010
  - 6: 0xCD and 11ccc100
  - 7: 0xC9 and 11ccc000
  - 8: 11nnn111
  - 0: all other opcodes
- R8: For 11ccc000, 11ccc010 and 11ccc100, `rec_taken` is 1 when flag bit `flag_vec[ccc[2:1]]` equals `ccc[0]`. Flag bit positions are: bit 0 zero, bit 1 carry, bit 2 parity, bit 3 sign. The flags are those present in the cycle the opcode byte is accepted.
- R9: `rec_taken` is 1 for 0xC3, 0xCD, 0xC9 and 11nnn111. It is 0 for every opcode in classes 0 to 4.
- R10: A reset in the middle of an instruction drops the bytes collected so far. The next byte accepted is treated as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_byte | input | 8 | Incoming instruction byte |
| in_valid | input | 1 | `in_byte` is offered |
| in_ready | output | 1 | Block can accept a byte |
| flag_vec | input | 4 | Condition flags {sign, parity, carry, zero} |
| rec_valid | output | 1 | Record is on the output |
| rec_ready | input | 1 | Consumer takes the record |
| rec_opcode | output | 8 | Opcode byte |
| rec_imm8 | output | 8 | Second byte |
| rec_imm16 | output | 16 | {third byte, second byte} |
| rec_len | output | 2 | Instruction length in bytes |
| rec_class | output | 4 | Class code per R7 |
| rec_taken | output | 1 | Control transfer taken |

## Verification
The properties assume that `in_byte` and `in_valid` are driven cleanly between edges. They also assume that `flag_vec` is meaningful only in the cycle the opcode is accepted. They make no assumption about when `rec_ready` arrives.

The stimulus drives every input at the falling edge. It holds each byte until a rising edge with `in_ready` high has taken it. It then scrambles `flag_vec` for the operand bytes, so that a design sampling the flags late gives a wrong taken bit. `rec_ready` is raised only after a random hold of zero to three cycles, which exercises the hold-steady behaviour.

// File: rtl/instr_gather_pkg.sv
package instr_gather_pkg;
  localparam int BYTE_W  = 8;
  localparam int FLAG_W  = 4;
  localparam int LEN_W   = 2;
  localparam int CLS_W   = 4;
  localparam int IMM_W   = 2 * BYTE_W;
  localparam int CC_W    = 3;

  typedef enum logic [CLS_W-1:0] {
    K_OTHER   = 4'd0,
    K_MOVE    = 4'd1,
    K_ALU     = 4'd2,
    K_IMMLD   = 4'd3,
    K_DIRECT  = 4'd4,
    K_JUMP    = 4'd5,
    K_CALL    = 4'd6,
    K_RETURN  = 4'd7,
    K_RESTART = 4'd8
  } iclass_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GATHER = 2'd1,
    ST_HOLD   = 2'd2
  } gstate_e;
endpackage

// File: rtl/op_shape_decode.sv
module op_shape_decode
  import instr_gather_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  output logic [LEN_W-1:0]  len,
  output iclass_e           cls,
  output logic              is_cond,
  output logic              is_always
);
  logic [1:0] top2;
  logic [2:0] low3;

  assign top2 = op[7:6];
  assign low3 = op[2:0];

  always_comb begin
    len       = 2'd1;
    cls       = K_OTHER;
    is_cond   = 1'b0;
    is_always = 1'b0;
    unique case (top2)
      2'b01: cls = K_MOVE;
      2'b10: cls = K_ALU;
      2'b00: begin
        if (low3 == 3'b110) begin
          len = 2'd2;
          cls = K_IMMLD;
        end else if (op[3:0] == 4'b0001) begin
          len = 2'd3;
          cls = K_IMMLD;
        end else if (low3 == 3'b010 && op[5]) begin
          len = 2'd3;
          cls = K_DIRECT;
        end
      end
      2'b11: begin
        unique case (low3)
          3'b000: begin cls = K_RETURN; is_cond = 1'b1; end
          3'b010: begin cls = K_JUMP; len = 2'd3; is_cond = 1'b1; end
          3'b100: begin cls = K_CALL; len = 2'd3; is_cond = 1'b1; end
          3'b110: begin cls = K_ALU; len = 2'd2; end
          3'b111: begin cls = K_RESTART; is_always = 1'b1; end
          3'b001: if (op[5:3] == 3'b001) begin cls = K_RETURN; is_always = 1'b1; end
          3'b011: if (op[5:3] == 3'b000) begin cls = K_JUMP; len = 2'd3; is_always = 1'b1; end
          3'b101: if (op[5:3] == 3'b001) begin cls = K_CALL; len = 2'd3; is_always = 1'b1; end
          default: cls = K_OTHER;
        endcase
      end
      default: cls = K_OTHER;
    endcase
  end
endmodule

// File: rtl/cond_check.sv
module cond_check
  import instr_gather_pkg::*;
(
  input  logic [CC_W-1:0]   cc,
  input  logic [FLAG_W-1:0] flags,
  output logic              hit
);
  // cc[2:1] picks the flag, cc[0] is the value that makes the test true
  logic picked;
  assign picked = flags[cc[2:1]];
  assign hit    = (picked == cc[0]);
endmodule

// File: rtl/byte_gather.sv
module byte_gather
  import instr_gather_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LEN_W-1:0]  dec_len,
  input  iclass_e           dec_cls,
  input  logic              dec_taken,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_op,
  output logic [BYTE_W-1:0] out_imm8,
  output logic [IMM_W-1:0]  out_imm16,
  output logic [LEN_W-1:0]  out_len,
  output iclass_e           out_cls,
  output logic              out_taken
);
  gstate_e           state_q, state_d;
  logic [LEN_W-1:0]  pos_q, pos_d;
  logic [LEN_W-1:0]  len_q;
  logic [BYTE_W-1:0] op_q, b2_q, b3_q, b2_d, b3_d;
  iclass_e           cls_q;
  logic              taken_q;
  logic              take, op_en, b2_en, b3_en;

  assign in_ready = (state_q != ST_HOLD);
  assign take     = in_valid && in_ready;
  assign op_en    = take && (state_q == ST_IDLE);
  assign b2_en    = op_en || (take && state_q == ST_GATHER && pos_q == 2'd1);
  assign b3_en    = op_en || (take && state_q == ST_GATHER && pos_q == 2'd2);
  assign b2_d     = op_en ? '0 : in_byte;
  assign b3_d     = op_en ? '0 : in_byte;

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take) begin
          pos_d   = 2'd1;
          state_d = (dec_len == 2'd1) ? ST_HOLD : ST_GATHER;
        end
      end
      ST_GATHER: begin
        if (take) begin
          pos_d = pos_q + 2'd1;
          if (pos_q + 2'd1 == len_q) state_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (out_ready) begin
          state_d = ST_IDLE;
          pos_d   = 2'd0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      len_q   <= '0;
      cls_q   <= K_OTHER;
      taken_q <= 1'b0;
    end else if (op_en) begin
      op_q    <= in_byte;
      len_q   <= dec_len;
      cls_q   <= dec_cls;
      taken_q <= dec_taken;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b2_q <= '0;
    end else if (b2_en) begin
      b2_q <= b2_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b3_q <= '0;
    end else if (b3_en) begin
      b3_q <= b3_d;
    end
  end

  assign out_valid = (state_q == ST_HOLD);
  assign out_op    = op_q;
  assign out_imm8  = b2_q;
  assign out_imm16 = (len_q == 2'd3) ? {b3_q, b2_q} : '0;
  assign out_len   = len_q;
  assign out_cls   = cls_q;
  assign out_taken = taken_q;
endmodule

// File: rtl/instr_gather.sv
module instr_gather
  import instr_gather_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BYTE_W-1:0]   in_byte,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [FLAG_W-1:0]   flag_vec,
  output logic                rec_valid,
  input  logic                rec_ready,
  output logic [BYTE_W-1:0]   rec_opcode,
  output logic [BYTE_W-1:0]   rec_imm8,
  output logic [IMM_W-1:0]    rec_imm16,
  output logic [LEN_W-1:0]    rec_len,
  output logic [CLS_W-1:0]    rec_class,
  output logic                rec_taken
);
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = rst_pipe[RST_STAGES-1];

  logic [LEN_W-1:0] dec_len;
  iclass_e          dec_cls;
  iclass_e          out_cls;
  logic             dec_cond, dec_always, cond_hit, dec_taken;

  op_shape_decode u_decode (
    .op        (in_byte),
    .len       (dec_len),
    .cls       (dec_cls),
    .is_cond   (dec_cond),
    .is_always (dec_always)
  );

  cond_check u_cond (
    .cc    (in_byte[5:3]),
    .flags (flag_vec),
    .hit   (cond_hit)
  );

  assign dec_taken = dec_always || (dec_cond && cond_hit);

  byte_gather u_gather (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .in_byte   (in_byte),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .dec_len   (dec_len),
    .dec_cls   (dec_cls),
    .dec_taken (dec_taken),
    .out_valid (rec_valid),
    .out_ready (rec_ready),
    .out_op    (rec_opcode),
    .out_imm8  (rec_imm8),
    .out_imm16 (rec_imm16),
    .out_len   (rec_len),
    .out_cls   (out_cls),
    .out_taken (rec_taken)
  );

  assign rec_class = out_cls;
endmodule

// File: rtl/instr_gather_chk.sv
module instr_gather_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        rec_valid,
  input logic        rec_ready,
  input logic [7:0]  rec_opcode,
  input logic [7:0]  rec_imm8,
  input logic [15:0] rec_imm16,
  input logic [1:0]  rec_len,
  input logic [3:0]  rec_class,
  input logic        rec_taken
);
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_opcode) && $stable(rec_imm8)
      && $stable(rec_imm16) && $stable(rec_len) && $stable(rec_class) && $stable(rec_taken));

  assert_no_accept_in_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> !in_ready);

  assert_rise_after_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_valid) |-> $past(in_valid && in_ready));

  assert_len_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_len != 2'd0);

  assert_short_imm16_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_len != 2'd3 |-> rec_imm16 == 16'h0000);

  assert_single_imm8_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_len == 2'd1 |-> rec_imm8 == 8'h00);

  assert_restart_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_class == 4'd8 |-> rec_taken);

  assert_plain_not_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_class < 4'd5 |-> !rec_taken);
endmodule

bind instr_gather instr_gather_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .rec_valid  (rec_valid),
  .rec_ready  (rec_ready),
  .rec_opcode (rec_opcode),
  .rec_imm8   (rec_imm8),
  .rec_imm16  (rec_imm16),
  .rec_len    (rec_len),
  .rec_class  (rec_class),
  .rec_taken  (rec_taken)
);

// File: tb/test_instr_gather.sv
`timescale 1ns/1ps
module test_instr_gather;
  logic        clk;
  logic        rst_n;
  logic [7:0]  in_byte;
  logic        in_valid;
  logic        in_ready;
  logic [3:0]  flag_vec;
  logic        rec_valid;
  logic        rec_ready;
  logic [7:0]  rec_opcode;
  logic [7:0]  rec_imm8;
  logic [15:0] rec_imm16;
  logic [1:0]  rec_len;
  logic [3:0]  rec_class;
  logic        rec_taken;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  instr_gather i_instr_gather (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
    .in_ready(in_ready), .flag_vec(flag_vec), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_opcode(rec_opcode), .rec_imm8(rec_imm8),
    .rec_imm16(rec_imm16), .rec_len(rec_len), .rec_class(rec_class),
    .rec_taken(rec_taken)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [7:0] op);
    if (op[7:6] == 2'b00 && op[2:0] == 3'b110) return 2;
    if (op[7:6] == 2'b11 && op[2:0] == 3'b110) return 2;
    if (op[7:6] == 2'b00 && op[3:0] == 4'b0001) return 3;
    if (op == 8'h22 || op == 8'h2A || op == 8'h32 || op == 8'h3A) return 3;
    if (op == 8'hC3 || op == 8'hCD) return 3;
    if (op[7:6] == 2'b11 && (op[2:0] == 3'b010 || op[2:0] == 3'b100)) return 3;
    return 1;
  endfunction

  function automatic int exp_cls(input logic [7:0] op);
    if (op[7:6] == 2'b01) return 1;
    if (op[7:6] == 2'b10) return 2;
    if (op[7:6] == 2'b11 && op[2:0] == 3'b110) return 2;
    if (op[7:6] == 2'b00 && (op[2:0] == 3'b110 || op[3:0] == 4'b0001)) return 3;
    if (op == 8'h22 || op == 8'h2A || op == 8'h32 || op == 8'h3A) return 4;
    if (op == 8'hC3 || (op[7:6] == 2'b11 && op[2:0] == 3'b010)) return 5;
    if (op == 8'hCD || (op[7:6] == 2'b11 && op[2:0] == 3'b100)) return 6;
    if (op == 8'hC9 || (op[7:6] == 2'b11 && op[2:0] == 3'b000)) return 7;
    if (op[7:6] == 2'b11 && op[2:0] == 3'b111) return 8;
    return 0;
  endfunction

  function automatic bit is_cond_op(input logic [7:0] op);
    return op[7:6] == 2'b11 && (op[2:0] == 3'b000 || op[2:0] == 3'b010 || op[2:0] == 3'b100);
  endfunction

  // flags: [0]=zero [1]=carry [2]=parity [3]=sign
  function automatic int exp_taken(input logic [7:0] op, input logic [3:0] f);
    if (is_cond_op(op)) begin
      case (op[5:3])
        3'd0: return int'(!f[0]);
        3'd1: return int'(f[0]);
        3'd2: return int'(!f[1]);
        3'd3: return int'(f[1]);
        3'd4: return int'(!f[2]);
        3'd5: return int'(f[2]);
        3'd6: return int'(!f[3]);
        default: return int'(f[3]);
      endcase
    end
    if (op == 8'hC3 || op == 8'hCD || op == 8'hC9) return 1;
    if (op[7:6] == 2'b11 && op[2:0] == 3'b111) return 1;
    return 0;
  endfunction

  task automatic put_byte(input logic [7:0] b, input logic [3:0] fl);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    flag_vec = fl;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_byte  = 8'($urandom);
    flag_vec = 4'($urandom);
  endtask

  task automatic run_instr(input logic [7:0] op, input logic [7:0] b2, input logic [7:0] b3,
                           input logic [3:0] fl, input int hold);
    int n;
    int e16;
    string ltag;
    n = exp_len(op);
    repeat ($urandom % 2) @(negedge clk);
    put_byte(op, fl);
    if (n >= 2) put_byte(b2, ~fl);
    if (n == 3) put_byte(b3, ~fl);
    check("R6", "rec_valid after last byte", int'(rec_valid), 1);
    check("R6", "in_ready while holding", int'(in_ready), 0);
    check("R7", "opcode", int'(rec_opcode), int'(op));
    ltag = (n == 2) ? "R2" : (n == 3) ? "R3" : "R4";
    check(ltag, "length", int'(rec_len), n);
    check("R7", "class", int'(rec_class), exp_cls(op));
    check(is_cond_op(op) ? "R8" : "R9", "taken", int'(rec_taken), exp_taken(op, fl));
    check("R5", "imm8", int'(rec_imm8), (n >= 2) ? int'(b2) : 0);
    e16 = (n == 3) ? int'({b3, b2}) : 0;
    check("R5", "imm16", int'(rec_imm16), e16);
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      check("R6", "held valid", int'(rec_valid), 1);
      check("R6", "held imm16", int'(rec_imm16), e16);
    end
    rec_ready = 1'b1;
    @(negedge clk);
    rec_ready = 1'b0;
    check("R6", "valid after take", int'(rec_valid), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; in_valid = 1'b0; in_byte = '0; flag_vec = '0; rec_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "in_ready after reset", int'(in_ready), 1);
    check("R1", "rec_valid after reset", int'(rec_valid), 0);

    // every opcode once
    for (int op = 0; op < 256; op++)
      run_instr(8'(op), 8'($urandom), 8'($urandom), 4'($urandom), $urandom % 3);

    // condition codes against both flag polarities
    for (int cc = 0; cc < 8; cc++) begin
      run_instr(8'hC2 | 8'(cc << 3), 8'h11, 8'h22, 4'h0, 0);
      run_instr(8'hC4 | 8'(cc << 3), 8'h33, 8'h44, 4'hF, 1);
      run_instr(8'hC0 | 8'(cc << 3), 8'h00, 8'h00, 4'h0, 0);
      run_instr(8'hC0 | 8'(cc << 3), 8'h00, 8'h00, 4'hF, 0);
    end

    // low-then-high corner
    run_instr(8'hC3, 8'hFF, 8'h00, 4'h0, 2);
    run_instr(8'h21, 8'h00, 8'hFF, 4'h0, 0);

    // R10: reset mid-instruction
    put_byte(8'hC3, 4'h0);
    put_byte(8'h34, 4'h0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10", "rec_valid in reset", int'(rec_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", "in_ready after reset", int'(in_ready), 1);
    check("R10", "rec_valid after reset", int'(rec_valid), 0);
    run_instr(8'h3E, 8'h55, 8'h00, 4'h0, 0);

    // random mix
    for (int k = 0; k < 400; k++)
      run_instr(8'($urandom), 8'($urandom), 8'($urandom), 4'($urandom), $urandom % 4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule